// File: doc/BRIEF.md
# ADC bus-interface timing controller

This block is the synchronous control logic between a microprocessor bus and an 8-bit two-step conversion core. It watches the active-low chip select, read and write strobes and a mode select input, all of which are asynchronous to the block clock. It sends a one-cycle start pulse to the core and takes back a result-valid pulse that carries the 8-bit code and an overflow bit. It holds the finished result in an output latch and drives the interrupt flag, the ready output and the data-bus enable.

Two bus protocols are supported. In write-then-read mode, a write strobe starts the conversion. An internal counter then places the result in the latch a fixed number of clock cycles after the write strobe is released. A read strobe that falls before the counter expires places the result in the latch at once and cancels the counter. In read-only mode, the read strobe both starts the conversion and collects the data. The ready output pulls the line low until the result has been latched. The analog front end, comparators and DAC stay in the core and are represented only by the handshake.

Top module: `adcbus_ctrl`

## Requirements
- R1: After reset, int_n is 1, rdy_oe is 0, bus_oe is 0, conv_start is 0 and the latch {dout_ovf, dout} reads 0.
- R2: With mode = 1 (write-then-read), a falling wr_n while cs_n is low produces exactly one conv_start pulse, one clock wide. A falling rd_n while the block is idle starts nothing.
- R3: In write-then-read mode, when the result is already valid, int_n falls exactly TIMEOUT_CYC+3 clock edges after wr_n rises. This covers two synchronizer stages, the edge detect and the counter. The result is latched at the same moment.
- R4: In write-then-read mode, a falling rd_n with cs_n low before the counter expires latches the result and drives int_n low within 3 edges. The counter is abandoned and never produces a second latch.
- R5: int_n returns to 1 after a rising edge of rd_n or of cs_n.
- R6: In write-then-read mode, bus_oe is 1 exactly while cs_n and rd_n are both low, after the synchronizer delay.
- R7: With mode = 0 (read-only), a falling rd_n while cs_n is low produces one conv_start pulse. The result is latched and int_n falls when the core signals completion. wr_n has no effect in this mode.
- R8: In read-only mode, bus_oe stays 0 until the current conversion has been latched. It is then 1 while cs_n and rd_n stay low.
- R9: In read-only mode, rdy_oe becomes 1 after cs_n falls and returns to 0 when the result is latched. rdy_o is always 0, so the line is either pulled low or released.
- R10: The latch captures the 8 data bits and the overflow bit from the core's result-valid cycle. It presents them on dout and dout_ovf unchanged until the next latch event.
- R11: A falling wr_n that arrives while a conversion is in progress produces no conv_start and does not restart the counter.
- R12: If the latch trigger (counter expiry or early read) comes before the core's result, the latch and the int_n fall wait for the result-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | Protocol select: 1 write-then-read, 0 read-only |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| conv_start | output | 1 | One-cycle request to the conversion core |
| conv_done | input | 1 | One-cycle result-valid pulse from the core |
| conv_data | input | 8 | Conversion code, valid with conv_done |
| conv_ovf | input | 1 | Overflow flag, valid with conv_done |
| int_n | output | 1 | Interrupt flag, low when a result is waiting |
| rdy_oe | output | 1 | Ready line enable: 1 pulls the line low |
| rdy_o | output | 1 | Ready line data value, tied to 0 |
| bus_oe | output | 1 | Data-bus output enable |
| dout | output | 8 | Latched conversion code |
| dout_ovf | output | 1 | Latched overflow flag |

## Verification
The bench counts clock edges from the write release to the interrupt. A counter that is off by one, or a missing synchronizer stage, shows up as the wrong edge number. It reads early in write-then-read mode and then waits well beyond the timeout. A design that keeps the counter running would drop the interrupt a second time. It sends a second write in the middle of a conversion and makes the core answer after the timeout. A design that restarts, or that latches stale data at expiry, shows an extra start pulse, an early interrupt or the wrong code. In read-only mode it checks that the bus stays disabled until the result is latched and that the ready line is released at that moment.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;
  localparam int DATA_W = 8;

  // bit positions of the synchronised bus inputs
  localparam int IDX_CS   = 0;
  localparam int IDX_RD   = 1;
  localparam int IDX_WR   = 2;
  localparam int IDX_MODE = 3;
  localparam int N_IN     = 4;

  typedef struct packed {
    logic              ovf;
    logic [DATA_W-1:0] code;
  } result_t;

  // bus enable rule: write-then-read opens on the strobes alone,
  // read-only additionally needs a latched, not-yet-restarted result
  function automatic logic oe_rule(input logic mode_wr, input logic cs_lo,
                                   input logic rd_lo, input logic have_res);
    return cs_lo & rd_lo & (mode_wr | have_res);
  endfunction
endpackage

// File: rtl/adcbus_sync.sv
module adcbus_sync #(
  parameter int              N       = 4,
  parameter logic [N-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] st1, st2, st3;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1[g] <= RST_VAL[g];
        st2[g] <= RST_VAL[g];
        st3[g] <= RST_VAL[g];
      end else begin
        st1[g] <= din[g];
        st2[g] <= st1[g];
        st3[g] <= st2[g];
      end
    end
    assign lvl[g]  = st2[g];
    assign rise[g] = st2[g] & ~st3[g];
    assign fall[g] = ~st2[g] & st3[g];
  end
endmodule

// File: rtl/adcbus_timer.sv
module adcbus_timer #(
  parameter int TIMEOUT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic running,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  assign expire = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (abort) begin
      running <= 1'b0;
    end else if (start) begin
      cnt     <= LOAD_VAL;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= step_down(cnt);
    end
  end

  // R3
  expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  // R4
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !running);
endmodule

// File: rtl/adcbus_seq.sv
module adcbus_seq
  import adcbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode_wr,
  input  logic    cs_lo,
  input  logic    rd_lo,
  input  logic    cs_fall,
  input  logic    cs_rise,
  input  logic    rd_fall,
  input  logic    rd_rise,
  input  logic    wr_fall,
  input  logic    wr_rise,
  input  logic    conv_done,
  input  result_t conv_res,
  input  logic    tmr_running,
  input  logic    tmr_expire,
  output logic    tmr_start,
  output logic    tmr_abort,
  output logic    conv_start,
  output result_t latch_q,
  output logic    int_n,
  output logic    rdy_oe,
  output logic    bus_oe
);
  logic    busy, res_ok, trig_pend, done_flag;
  result_t hold;

  // named internal events
  logic    start_req, early_rd, trig_now, res_avail, latch_fire, oe_next;
  result_t res_sel;

  always_comb begin
    start_req  = !busy && cs_lo &&
                 (mode_wr ? wr_fall : rd_fall);
    early_rd   = mode_wr && busy && cs_lo && rd_fall && !trig_pend;
    trig_now   = busy && (mode_wr ? (tmr_expire || early_rd) : 1'b1);
    res_avail  = res_ok || (busy && conv_done);
    latch_fire = busy && res_avail && (trig_pend || trig_now);
    res_sel    = res_ok ? hold : conv_res;
    tmr_start  = mode_wr && busy && wr_rise && !tmr_running && !trig_pend;
    tmr_abort  = early_rd;
    oe_next    = oe_rule(mode_wr, cs_lo, rd_lo, done_flag && !start_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      res_ok     <= 1'b0;
      trig_pend  <= 1'b0;
      done_flag  <= 1'b0;
      hold       <= '0;
      latch_q    <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= start_req;
      if (start_req) begin
        busy      <= 1'b1;
        res_ok    <= 1'b0;
        trig_pend <= 1'b0;
        done_flag <= 1'b0;
      end else if (latch_fire) begin
        busy      <= 1'b0;
        res_ok    <= 1'b0;
        trig_pend <= 1'b0;
        done_flag <= 1'b1;
        latch_q   <= res_sel;
      end else if (busy) begin
        if (conv_done) begin
          res_ok <= 1'b1;
          hold   <= conv_res;
        end
        if (trig_now) trig_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_n  <= 1'b1;
      rdy_oe <= 1'b0;
      bus_oe <= 1'b0;
    end else begin
      if (latch_fire)              int_n <= 1'b0;
      else if (rd_rise || cs_rise) int_n <= 1'b1;

      if (latch_fire)              rdy_oe <= 1'b0;
      else if (!mode_wr && cs_fall) rdy_oe <= 1'b1;

      bus_oe <= oe_next;
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy));
  // R4
  latch_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> (!int_n && !busy));
  // R5
  int_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_rise || cs_rise) && !latch_fire) |=> int_n);
  // R9
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> !rdy_oe);
  // R8
  oe_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !mode_wr && $stable(mode_wr)) |-> done_flag);
endmodule

// File: rtl/adcbus_ctrl.sv
module adcbus_ctrl
  import adcbus_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_ovf,
  output logic              int_n,
  output logic              rdy_oe,
  output logic              rdy_o,
  output logic              bus_oe,
  output logic [DATA_W-1:0] dout,
  output logic              dout_ovf
);
  localparam logic [N_IN-1:0] SYNC_RST = N_IN'(4'b0111);

  logic [N_IN-1:0] raw_in, s_lvl, s_rise, s_fall;
  logic            tmr_start, tmr_abort, tmr_running, tmr_expire;
  result_t         conv_res, latch_q;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_CS]   = cs_n;
    raw_in[IDX_RD]   = rd_n;
    raw_in[IDX_WR]   = wr_n;
    raw_in[IDX_MODE] = mode;
  end

  assign conv_res = '{ovf: conv_ovf, code: conv_data};

  adcbus_sync #(.N(N_IN), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_in),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  adcbus_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .abort  (tmr_abort),
    .running(tmr_running),
    .expire (tmr_expire)
  );

  adcbus_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (s_lvl[IDX_MODE]),
    .cs_lo      (!s_lvl[IDX_CS]),
    .rd_lo      (!s_lvl[IDX_RD]),
    .cs_fall    (s_fall[IDX_CS]),
    .cs_rise    (s_rise[IDX_CS]),
    .rd_fall    (s_fall[IDX_RD]),
    .rd_rise    (s_rise[IDX_RD]),
    .wr_fall    (s_fall[IDX_WR]),
    .wr_rise    (s_rise[IDX_WR]),
    .conv_done  (conv_done),
    .conv_res   (conv_res),
    .tmr_running(tmr_running),
    .tmr_expire (tmr_expire),
    .tmr_start  (tmr_start),
    .tmr_abort  (tmr_abort),
    .conv_start (conv_start),
    .latch_q    (latch_q),
    .int_n      (int_n),
    .rdy_oe     (rdy_oe),
    .bus_oe     (bus_oe)
  );

  assign dout     = latch_q.code;
  assign dout_ovf = latch_q.ovf;
  assign rdy_o    = 1'b0;
endmodule

// File: tb/test_adcbus_ctrl.sv
module test_adcbus_ctrl;
  localparam int T = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic       conv_done = 1'b0, conv_ovf = 1'b0;
  logic [7:0] conv_data = '0;
  logic       conv_start, int_n, rdy_oe, rdy_o, bus_oe, dout_ovf;
  logic [7:0] dout;

  int checks = 0, failures = 0;
  int n_start = 0;
  int n_latch = 0;
  int conv_lat = 4;
  logic [8:0] next_res = '0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  adcbus_ctrl #(.TIMEOUT_CYC(T)) i_adcbus_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
    .conv_ovf(conv_ovf), .int_n(int_n), .rdy_oe(rdy_oe), .rdy_o(rdy_o),
    .bus_oe(bus_oe), .dout(dout), .dout_ovf(dout_ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver side of the scoreboard: set the core's answer and expect it
  task automatic push_result(input logic ovf, input logic [7:0] code);
    next_res = {ovf, code};
    exp_q.push_back({ovf, code});
  endtask

  task automatic wait_int_low(input int maxc, output int n);
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (!int_n) begin n = i; break; end
    end
  endtask

  // start pulse counter (one count per high cycle)
  initial forever begin
    @(negedge clk);
    if (conv_start) n_start++;
  end

  // conversion core model
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      repeat (conv_lat - 1) @(negedge clk);
      conv_done = 1'b1;
      {conv_ovf, conv_data} = next_res;
      @(negedge clk);
      conv_done = 1'b0;
      conv_data = 8'hxx;
    end
  end

  // monitor side of the scoreboard: compare latch on each int_n fall
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (prev && !int_n) begin
        n_latch++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected latch", int'({dout_ovf, dout}), -1);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({dout_ovf, dout} === e, "R10 latched value", int'({dout_ovf, dout}), int'(e));
        end
      end
      prev = int_n;
    end
  end

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, s0, l0, first;
    tick(3);
    // R1 reset state
    chk(int_n === 1'b1, "R1 int_n", int'(int_n), 1);
    chk(rdy_oe === 1'b0 && bus_oe === 1'b0, "R1 enables", int'({rdy_oe, bus_oe}), 0);
    chk(conv_start === 1'b0 && {dout_ovf, dout} === 9'h0, "R1 latch", int'({dout_ovf, dout}), 0);
    rst_n = 1'b1;
    tick(2);

    // ---- write-then-read, timeout path (R2, R3, R6, R10) ----
    mode = 1'b1; cs_n = 1'b0; tick(4);
    s0 = n_start;
    rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(4);
    chk(n_start == s0, "R2 idle read starts nothing", n_start - s0, 0);
    push_result(1'b0, 8'h5A);
    wr_n = 1'b0; tick(3); wr_n = 1'b1;
    first = 0;
    for (int i = 1; i <= T + 8; i++) begin
      @(negedge clk);
      if (!int_n && first == 0) first = i;
    end
    chk(n_start == s0 + 1, "R2 one start pulse", n_start - s0, 1);
    chk(first == T + 3, "R3 timeout edge count", first, T + 3);
    chk(bus_oe === 1'b0, "R6 bus off while rd high", int'(bus_oe), 0);
    rd_n = 1'b0; tick(4);
    chk(bus_oe === 1'b1, "R6 bus on with cs,rd low", int'(bus_oe), 1);
    rd_n = 1'b1; tick(4);
    chk(int_n === 1'b1, "R5 rd rise clears int", int'(int_n), 1);
    chk(bus_oe === 1'b0, "R6 bus off after rd rise", int'(bus_oe), 0);
    cs_n = 1'b1; tick(4);

    // ---- early read (R4) ----
    cs_n = 1'b0; tick(4);
    push_result(1'b1, 8'hA5);
    wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(10);
    chk(int_n === 1'b1, "R4 no latch before read", int'(int_n), 1);
    rd_n = 1'b0; tick(3);
    chk(int_n === 1'b0, "R4 early read latches", int'(int_n), 0);
    l0 = n_latch;
    rd_n = 1'b1; tick(3);
    chk(int_n === 1'b1, "R5 clear after early read", int'(int_n), 1);
    tick(T + 10);
    chk(int_n === 1'b1 && n_latch == l0, "R4 timer abandoned", n_latch - l0, 0);
    cs_n = 1'b1; tick(4);

    // ---- cs rise clears int (R5) ----
    cs_n = 1'b0; tick(4);
    push_result(1'b0, 8'hFF);
    wr_n = 1'b0; tick(2); wr_n = 1'b1;
    wait_int_low(T + 10, n);
    chk(n != 0, "R3 latch on timeout", n, T + 3);
    cs_n = 1'b1; tick(4);
    chk(int_n === 1'b1, "R5 cs rise clears int", int'(int_n), 1);

    // ---- busy write ignored, late result (R11, R12) ----
    conv_lat = T + 25;
    cs_n = 1'b0; tick(4);
    s0 = n_start;
    push_result(1'b1, 8'h00);
    wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(5);
    wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(4);
    chk(n_start == s0 + 1, "R11 busy write ignored", n_start - s0, 1);
    tick(T + 2);
    chk(int_n === 1'b1, "R12 waits for result", int'(int_n), 1);
    wait_int_low(60, n);
    chk(n != 0, "R12 latch after late result", n, 1);
    rd_n = 1'b0; tick(3); rd_n = 1'b1; tick(3);
    cs_n = 1'b1; tick(4);
    conv_lat = 6;

    // ---- read-only mode (R7, R8, R9) ----
    mode = 1'b0; tick(4);
    chk(rdy_oe === 1'b0, "R9 rdy idle", int'(rdy_oe), 0);
    cs_n = 1'b0; tick(4);
    chk(rdy_oe === 1'b1 && rdy_o === 1'b0, "R9 rdy pulled after cs fall", int'({rdy_oe, rdy_o}), 2);
    s0 = n_start;
    wr_n = 1'b0; tick(3); wr_n = 1'b1; tick(4);
    chk(n_start == s0, "R7 write ignored in read mode", n_start - s0, 0);
    push_result(1'b0, 8'h3C);
    rd_n = 1'b0; tick(4);
    chk(bus_oe === 1'b0, "R8 bus off during conversion", int'(bus_oe), 0);
    wait_int_low(30, n);
    chk(n != 0 && n_start == s0 + 1, "R7 read starts and latches", n_start - s0, 1);
    chk(rdy_oe === 1'b0, "R9 rdy released at latch", int'(rdy_oe), 0);
    tick(2);
    chk(bus_oe === 1'b1, "R8 bus on after latch", int'(bus_oe), 1);
    rd_n = 1'b1; tick(4);
    chk(int_n === 1'b1 && bus_oe === 1'b0, "R5 read-mode rd rise", int'({int_n, bus_oe}), 2);
    cs_n = 1'b1; tick(4);

    tick(4);
    chk(exp_q.size() == 0, "R10 all results latched", exp_q.size(), 0);
    finish_run();
  end
endmodule